// File: doc/BRIEF.md
# Guarded Configuration Aperture

This block turns memory reads and writes that land in a 4 KB address aperture into accesses on a configuration register file. The register file has the same layout as configuration space. Any bus master can then reach configuration registers through ordinary memory requests, not only a root. Address bit 11 picks the half. The lower 2 KB reach the local register set. The upper 2 KB reach the opposite side's register set at the same offsets.

A lock input hides one capability structure in both halves. While the lock is set, every dword of that structure except its header reads as zero and ignores writes. The header keeps its constant value, so software can still walk the capability list. The aperture accepts 1, 2 and 4 byte accesses that are naturally aligned. Any other access is flagged and has no effect.

Reads complete one cycle after they are accepted. Each completion carries the request's tag, and a completion is held until downstream accepts it. No more than four reads may be outstanding at once. A read that arrives while four are pending is dropped silently.

Top module: `cfgwin_top`

## Requirements
- R1: The access length `req_len` (a byte count) is valid only when it is 1, 2 with `req_addr[0]`=0, or 4 with `req_addr[1:0]`=0. Any other request raises `req_bad` for one cycle, one cycle after the request, and has no other effect.
- R2: A valid write updates only the byte lanes it covers, where lane n is `req_wdata[8n+7:8n]` for byte address offset n. The other lanes of the dword keep their values.
- R3: A valid read that is accepted shows `cpl_valid` in the next cycle, with its `req_tag` on `cpl_tag`. `cpl_data` carries the covered lanes in place and zero in the uncovered lanes.
- R4: `req_addr[11]`=0 selects the local register set and `req_addr[11]`=1 selects the opposite set. Dword index `req_addr[10:2]` is the same in both sets, and the two sets are independent.
- R5: While `cap_lock`=1, reads of the capability body return zero in both halves. The body is the dwords after the header, up to CAP_BASE+CAP_LEN.
- R6: While `cap_lock`=1, writes to the capability body are discarded in both halves. Their data is not visible after the lock is cleared.
- R7: The header dword at CAP_BASE always reads CAP_HDR in both halves, whatever `cap_lock` holds, and writes to it are ignored.
- R8: At most MAX_OUT (4) reads are outstanding. A read that arrives while MAX_OUT are pending is dropped and never produces a completion.
- R9: A completion stays on the outputs, unchanged, until `cpl_ready` is 1. A read credit is returned only when downstream takes the completion, and a following read is then accepted.
- R10: Dwords at or beyond IMPL_DW in either half read as zero, and writes to them have no effect.
- R11: After reset, every implemented dword other than the header reads zero, and `cpl_valid` and `req_bad` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_lock | input | 1 | Hides the capability body in both halves |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the aperture |
| req_len | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, byte lanes aligned to the address |
| req_tag | input | TAG_W | Read tag returned with the completion |
| req_bad | output | 1 | Pulse: the previous request had an unsupported size or alignment |
| cpl_valid | output | 1 | Completion available |
| cpl_ready | input | 1 | Downstream takes the completion |
| cpl_tag | output | TAG_W | Tag of the completion |
| cpl_data | output | 32 | Read data of the completion |

## Verification
Each request is driven on a falling edge and takes effect at the next rising edge. The completion and the `req_bad` pulse of a read are therefore both due one cycle after the request, and the bench samples them at the following falling edge, half a cycle after they settle. A write has no output of its own, so its effect is checked by a read in a later cycle. To test the credit limit, the bench withholds `cpl_ready` and issues five reads back to back. It then releases the queue and expects exactly four tags, in order, one per cycle, and after that no completion. Expected values come from a software model of both register sets that applies the lock, header and range rules.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int WIN_AW    = 12;           // 4 KB aperture
  localparam int HALF_DW_W = WIN_AW - 3;   // dword index inside one 2 KB half

  typedef struct packed {
    logic                 side;  // 0 local, 1 opposite
    logic [HALF_DW_W-1:0] dw;
    logic [3:0]           be;
    logic                 bad;
    logic                 hdr;   // capability header dword
    logic                 body;  // capability dwords after the header
  } win_dec_t;
endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int CAP_BASE = 256,
  parameter int CAP_LEN  = 32
) (
  input  logic [WIN_AW-1:0] addr,
  input  logic [2:0]        len,
  output win_dec_t          dec
);
  localparam int HDR_DW = CAP_BASE / 4;
  localparam int END_DW = (CAP_BASE + CAP_LEN) / 4;

  logic [1:0] ofs;
  assign ofs = addr[1:0];

  always_comb begin
    dec.side = addr[WIN_AW-1];
    dec.dw   = addr[WIN_AW-2:2];
    dec.be   = 4'b0000;
    dec.bad  = 1'b0;
    // R1: size and natural alignment
    unique case (len)
      3'd1: dec.be = 4'b0001 << ofs;
      3'd2: if (!ofs[0]) dec.be = 4'b0011 << ofs; else dec.bad = 1'b1;
      3'd4: if (ofs == 2'd0) dec.be = 4'b1111; else dec.bad = 1'b1;
      default: dec.bad = 1'b1;
    endcase
    dec.hdr  = (dec.dw == HALF_DW_W'(HDR_DW));
    dec.body = (dec.dw > HALF_DW_W'(HDR_DW)) && (dec.dw < HALF_DW_W'(END_DW));
  end
endmodule

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
  import cfgwin_pkg::*;
#(
  parameter int          IMPL_DW = 96,
  parameter int          HDR_DW  = 64,
  parameter logic [31:0] CAP_HDR = 32'h0018_A50D
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_side,
  input  logic [HALF_DW_W-1:0] wr_dw,
  input  logic [3:0]           wr_be,
  input  logic [31:0]          wr_data,
  input  logic                 rd_side,
  input  logic [HALF_DW_W-1:0] rd_dw,
  output logic [31:0]          rd_data
);
  logic [31:0] word [2][IMPL_DW];

  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar i = 0; i < IMPL_DW; i++) begin : g_word
      if (i == HDR_DW) begin : g_hdr
        // R7: header is a constant, writes have no target
        assign word[s][i] = CAP_HDR;
      end else begin : g_rw
        logic [31:0] q_r, q_nxt;
        logic        hit;
        assign hit = wr_en && (wr_side == 1'(s)) && (wr_dw == HALF_DW_W'(i));
        always_comb begin
          q_nxt = q_r;
          for (int b = 0; b < 4; b++)
            if (wr_be[b]) q_nxt[8*b +: 8] = wr_data[8*b +: 8];   // R2
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q_r <= '0;        // R11
          else if (hit) q_r <= q_nxt;
        end
        assign word[s][i] = q_r;
      end
    end
  end

  // R10: indices outside the implemented range read zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < IMPL_DW; i++)
      if (rd_dw == HALF_DW_W'(i)) rd_data = word[rd_side][i];
  end
endmodule

// File: rtl/cfgwin_credit.sv
module cfgwin_credit #(
  parameter int MAX_OUT = 4,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic          full,
  output logic [CW-1:0] outstanding
);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = outstanding;
    if (take && !give)      cnt_nxt = outstanding + 1'b1;
    else if (give && !take) cnt_nxt = outstanding - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           outstanding <= '0;
    else if (take ^ give) outstanding <= cnt_nxt;
  end

  assign full = (outstanding == CW'(MAX_OUT));

  a_r8_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CW'(MAX_OUT));
  a_r8_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(take && !give) || 1'b0 == 1'b1 || !take);
endmodule

// File: rtl/cfgwin_cplq.sv
module cfgwin_cplq #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 36,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             valid,
  output logic [WIDTH-1:0] head
);
  logic [WIDTH-1:0] slot [DEPTH];
  logic [PW-1:0]    wp, rp, wp_nxt, rp_nxt;
  logic [CW-1:0]    cnt, cnt_nxt;

  always_comb begin
    wp_nxt  = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    rp_nxt  = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    cnt_nxt = cnt;
    if (push && !pop)      cnt_nxt = cnt + 1'b1;
    else if (pop && !push) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)        wp  <= wp_nxt;
      if (pop)         rp  <= rp_nxt;
      if (push ^ pop)  cnt <= cnt_nxt;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wp == PW'(i))) slot[i] <= push_data;
    end
  end

  assign valid = (cnt != '0);
  assign head  = slot[rp];

  a_r8_q_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !(push && !pop));
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int          CAP_BASE = 256,
  parameter int          CAP_LEN  = 32,
  parameter int          IMPL_DW  = 96,
  parameter logic [31:0] CAP_HDR  = 32'h0018_A50D,
  parameter int          MAX_OUT  = 4,
  parameter int          TAG_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_lock,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIN_AW-1:0] req_addr,
  input  logic [2:0]        req_len,
  input  logic [31:0]       req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              req_bad,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [31:0]       cpl_data
);
  localparam int HDR_DW = CAP_BASE / 4;
  localparam int QW     = TAG_W + 32;
  localparam int CW     = $clog2(MAX_OUT + 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_q   <= 1'b1;
      rst_n_s <= rst_q;
    end
  end

  win_dec_t dec;
  cfgwin_decode #(.CAP_BASE(CAP_BASE), .CAP_LEN(CAP_LEN)) u_dec (
    .addr(req_addr), .len(req_len), .dec(dec));

  logic        hidden, wr_en, rd_try, push, pop, full;
  logic [31:0] raw, lane_mask, rd_val;
  logic [CW-1:0] outstanding;
  logic [QW-1:0] q_head;

  assign hidden = cap_lock && dec.body;                               // R5 R6
  assign wr_en  = req_valid && req_write && !dec.bad && !hidden;
  assign rd_try = req_valid && !req_write && !dec.bad;
  assign push   = rd_try && !full;                                    // R8
  assign pop    = cpl_valid && cpl_ready;                             // R9

  cfgwin_regfile #(.IMPL_DW(IMPL_DW), .HDR_DW(HDR_DW), .CAP_HDR(CAP_HDR)) u_rf (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(wr_en), .wr_side(dec.side), .wr_dw(dec.dw), .wr_be(dec.be), .wr_data(req_wdata),
    .rd_side(dec.side), .rd_dw(dec.dw), .rd_data(raw));

  always_comb begin
    for (int b = 0; b < 4; b++) lane_mask[8*b +: 8] = {8{dec.be[b]}};
    rd_val = hidden ? '0 : (raw & lane_mask);                         // R3
  end

  cfgwin_credit #(.MAX_OUT(MAX_OUT)) u_cr (
    .clk(clk), .rst_n(rst_n_s), .take(push), .give(pop),
    .full(full), .outstanding(outstanding));

  cfgwin_cplq #(.DEPTH(MAX_OUT), .WIDTH(QW)) u_q (
    .clk(clk), .rst_n(rst_n_s), .push(push), .push_data({req_tag, rd_val}),
    .pop(pop), .valid(cpl_valid), .head(q_head));

  assign {cpl_tag, cpl_data} = q_head;

  // R1: flag pulse one cycle after an unsupported request
  logic bad_nxt;
  assign bad_nxt = req_valid && dec.bad;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) req_bad <= 1'b0;
    else          req_bad <= bad_nxt;
  end

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n_s)
    push |=> cpl_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_tag) && $stable(cpl_data)));
  a_r8_drop_full: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_try && full && !pop) |=> (outstanding == $past(outstanding)));
  a_r8_credit_match: assert property (@(posedge clk) disable iff (!rst_n_s)
    cpl_valid == (outstanding != '0));
  a_r7_header_const: assert property (@(posedge clk) disable iff (!rst_n_s)
    (push && dec.hdr && dec.be == 4'hF) |-> (rd_val == CAP_HDR));
endmodule

// File: tb/cfgwin_top_tb.sv
module cfgwin_top_tb_top;
  localparam int          NDW   = 96;
  localparam int          HDR   = 64;
  localparam int          BODY_LO = 65;
  localparam int          BODY_HI = 71;
  localparam logic [31:0] HVAL  = 32'h0018_A50D;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cap_lock, req_valid, req_write, req_bad, cpl_valid, cpl_ready;
  logic [11:0] req_addr;
  logic [2:0]  req_len;
  logic [31:0] req_wdata, cpl_data;
  logic [3:0]  req_tag, cpl_tag;

  cfgwin_top dut_i (
    .clk(clk), .rst_n(rst_n), .cap_lock(cap_lock), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .req_tag(req_tag), .req_bad(req_bad), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_tag(cpl_tag), .cpl_data(cpl_data));

  int n_run = 0, n_fail = 0;
  logic [31:0] mdl [2][NDW];

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit good_acc(input int len, input int ofs);
    return (len == 1) || (len == 2 && ofs % 2 == 0) || (len == 4 && ofs == 0);
  endfunction

  function automatic logic [31:0] lanes(input int len, input int ofs);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (b >= ofs && b < ofs + len) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] exp_rd(input int s, input int dw, input int len, input int ofs);
    logic [31:0] v;
    if (dw >= NDW)                                  v = '0;
    else if (dw == HDR)                             v = HVAL;
    else if (cap_lock && dw >= BODY_LO && dw <= BODY_HI) v = '0;
    else                                            v = mdl[s][dw];
    return v & lanes(len, ofs);
  endfunction

  function automatic logic [11:0] mk(input int s, input int dw, input int ofs);
    return 12'((s << 11) | (dw << 2) | ofs);
  endfunction

  task automatic wr(input int s, input int dw, input int len, input int ofs,
                    input logic [31:0] d, input string rq);
    logic [31:0] m;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = mk(s, dw, ofs); req_len = 3'(len); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check({rq, " bad flag"}, {31'b0, req_bad}, {31'b0, !good_acc(len, ofs)});
    if (good_acc(len, ofs) && dw < NDW && dw != HDR &&
        !(cap_lock && dw >= BODY_LO && dw <= BODY_HI)) begin
      m = lanes(len, ofs);
      mdl[s][dw] = (mdl[s][dw] & ~m) | (d & m);
    end
  endtask

  task automatic rd(input int s, input int dw, input int len, input int ofs,
                    input logic [3:0] tag, input string rq);
    bit g;
    logic [31:0] e;
    g = good_acc(len, ofs);
    e = exp_rd(s, dw, len, ofs);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = mk(s, dw, ofs); req_len = 3'(len); req_tag = tag;
    @(negedge clk);
    req_valid = 0;
    check({rq, " valid"}, {31'b0, cpl_valid}, {31'b0, g});
    check({rq, " bad flag"}, {31'b0, req_bad}, {31'b0, !g});
    if (g) begin
      check({rq, " tag"}, {28'b0, cpl_tag}, {28'b0, tag});
      check({rq, " data"}, cpl_data, e);
    end
  endtask

  function automatic logic [31:0] pat(input int s, input int i, input int k);
    return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(s * 32'h0F0F_0000) ^ 32'(k * 32'h0001_0203);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) for (int i = 0; i < NDW; i++) mdl[s][i] = '0;
    rst_n = 0; cap_lock = 0; req_valid = 0; req_write = 0; req_addr = '0;
    req_len = 3'd4; req_wdata = '0; req_tag = '0; cpl_ready = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R11: reset state
    check("R11 cpl_valid", {31'b0, cpl_valid}, 32'd0);
    check("R11 req_bad", {31'b0, req_bad}, 32'd0);
    for (int s = 0; s < 2; s++) for (int i = 0; i < NDW; i++) rd(s, i, 4, 0, 4'(i), "R11");

    // R4: fill both halves with distinct data, read back
    for (int s = 0; s < 2; s++) for (int i = 0; i < NDW; i++) wr(s, i, 4, 0, pat(s, i, 1), "R4");
    for (int s = 0; s < 2; s++) for (int i = 0; i < NDW; i++) rd(s, i, 4, 0, 4'(i + s), "R4");

    // R7: header unaffected by writes, lock off
    wr(0, HDR, 4, 0, 32'hFFFF_FFFF, "R7");
    wr(1, HDR, 2, 2, 32'h1234_5678, "R7");
    rd(0, HDR, 4, 0, 4'h1, "R7");
    rd(1, HDR, 4, 0, 4'h2, "R7");

    // R5: locked reads of body give zero in both halves, header intact
    cap_lock = 1;
    for (int s = 0; s < 2; s++) for (int i = 60; i < 76; i++) rd(s, i, 4, 0, 4'(i), "R5");
    rd(1, HDR, 4, 0, 4'h3, "R7");

    // R6: locked writes to body discarded, outside body accepted
    for (int s = 0; s < 2; s++) for (int i = 60; i < 76; i++) wr(s, i, 4, 0, pat(s, i, 7), "R6");
    cap_lock = 0;
    for (int s = 0; s < 2; s++) for (int i = 60; i < 76; i++) rd(s, i, 4, 0, 4'(i), "R6");

    // R10: beyond implemented range
    wr(0, 200, 4, 0, 32'hDEAD_BEEF, "R10");
    wr(1, 511, 4, 0, 32'hDEAD_BEEF, "R10");
    rd(0, 200, 4, 0, 4'h5, "R10");
    rd(1, 511, 4, 0, 4'h6, "R10");
    rd(0, NDW, 4, 0, 4'h7, "R10");

    // R1 R2 R3: every length and offset on one dword of each half
    for (int s = 0; s < 2; s++)
      for (int len = 0; len < 8; len++)
        for (int ofs = 0; ofs < 4; ofs++) begin
          wr(s, 5, len, ofs, pat(s, len, ofs), "R2");
          rd(s, 5, 4, 0, 4'(len), "R2");
          rd(s, 5, len, ofs, 4'(ofs), "R3");
        end

    // R8 R9: credit limit with completions withheld
    cpl_ready = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = mk(0, k, 0); req_len = 3'd4; req_tag = 4'(k);
    end
    @(negedge clk);
    req_valid = 0;
    check("R9 held valid", {31'b0, cpl_valid}, 32'd1);
    check("R9 held tag", {28'b0, cpl_tag}, 32'd1);
    @(negedge clk);
    check("R9 still held tag", {28'b0, cpl_tag}, 32'd1);
    check("R9 still held data", cpl_data, mdl[0][1]);
    cpl_ready = 1;
    for (int k = 1; k <= 4; k++) begin
      check("R8 drain valid", {31'b0, cpl_valid}, 32'd1);
      check("R8 drain tag", {28'b0, cpl_tag}, 32'(k));
      check("R8 drain data", cpl_data, mdl[0][k]);
      @(negedge clk);
    end
    check("R8 fifth read dropped", {31'b0, cpl_valid}, 32'd0);
    rd(0, 9, 4, 0, 4'hA, "R9 credit returned");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule